// File: doc/BRIEF.md
# Modulo and Reverse-Carry Address Update Unit

This block computes the next value of one 16-bit address pointer. Each update takes three inputs: the pointer's current value, a paired offset value and a paired modifier value. A two-bit step select chooses the update: add one, subtract one, add the offset or subtract the offset. The modifier picks the arithmetic used for the update:

- **Linear:** plain wrapping arithmetic over the whole 16-bit space.
- **Circular:** the pointer stays inside a buffer of M words, with the buffer placed on a power-of-two boundary.
- **Bit-reversed:** the carry runs from the most significant bit toward the least significant bit, which walks FFT data in bit-reversed order.

Three results are formed side by side in the same cycle. The first is a plain sum of pointer and step. The second is a correction of that sum by plus or minus M. The third is a sum with the carry reversed. Wrap-test logic then picks the circular result.

The caller presents the operands together with a valid strobe. One cycle later the updated pointer appears with its own valid flag. Register storage and instruction decoding belong to the surrounding address unit.

Top module: `agu_update`

## Requirements
- R1: With the modifier at 16'hFFFF the result is the address plus the step, modulo 2^16. The step select is encoded as 2'b00 for +1, 2'b01 for -1, 2'b10 for +offset and 2'b11 for -offset.
- R2: Modifier values from 16'h8000 to 16'hFFFE behave exactly like linear mode.
- R3: A modifier value m from 1 to 16'h7FFF selects circular mode with buffer size M = m+1. Call the smallest power of two not below M by the name P. The buffer base is the address with its low log2(P) bits cleared, and the top of the buffer is base+m. When the plain sum stays within [base, base+m], that sum is the result.
- R4: In circular mode, with an upward step (+1 or +offset) whose sum passes base+m, the result is the sum minus M. This assumes the step is at most M.
- R5: In circular mode, with a downward step (-1 or -offset) whose sum drops below the base, the result is the sum plus M. A sum that borrows below zero counts as below the base.
- R6: With the modifier at 16'h0000 an upward step gives rev(rev(addr) + rev(step)), where rev mirrors the 16 bits. From 0, repeated +offset with offset 16'h8000 yields 16'h8000, 16'h4000, 16'hC000, 16'h2000 and so on.
- R7: In bit-reversed mode a downward step gives rev(rev(addr) - rev(step)). With offset 16'h8000, repeated -offset from 16'hC000 yields 16'h4000, 16'h8000, 16'h0000.
- R8: `out_valid` is `in_valid` delayed by one clock. `addr_out` loads only on a cycle with `in_valid` high and otherwise holds its value whatever the other inputs do.
- R9: While reset is asserted, `out_valid` and `addr_out` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands valid this cycle |
| addr_in | input | 16 | Current pointer value |
| offset_in | input | 16 | Paired offset value |
| modifier_in | input | 16 | Paired modifier (arithmetic select) |
| step_sel | input | 2 | Step: 00 +1, 01 -1, 10 +offset, 11 -offset |
| out_valid | output | 1 | Updated pointer valid |
| addr_out | output | 16 | Updated pointer |

## Verification
In circular mode the plain sum and the M-corrected sum are computed in the same cycle, and the wrap test must choose between them. The bench provokes this choice with steps that land exactly on the top of the buffer and exactly on the base, where the plain sum must win. It also uses steps one word beyond either end, an offset equal to M, a base of zero and a buffer ending at 16'hFFFF, where the corrected sum must win. Every result is judged against values worked out from the base and bound rules.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [1:0] {
    STEP_INC  = 2'b00,
    STEP_DEC  = 2'b01,
    STEP_ADDN = 2'b10,
    STEP_SUBN = 2'b11
  } step_e;

  typedef enum logic [1:0] {
    ARITH_LIN = 2'b00,
    ARITH_MOD = 2'b01,
    ARITH_REV = 2'b10
  } arith_e;

endpackage

// File: rtl/agu_offset_add.sv
// Plain adder: address plus or minus the selected magnitude, with one extra bit
// kept so the wrap logic sees overflow past the top and borrow below zero.
module agu_offset_add #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] offset,
  input  logic [1:0]    step,
  output logic [AW-1:0] mag,
  output logic          down,
  output logic [AW:0]   sum_ext
);
  localparam logic [AW-1:0] ONE = AW'(1);

  always_comb begin
    mag  = step[1] ? offset : ONE;
    down = step[0];
    if (down) sum_ext = {1'b0, addr} - {1'b0, mag};
    else      sum_ext = {1'b0, addr} + {1'b0, mag};
  end
endmodule

// File: rtl/agu_mod_wrap.sv
// Circular correction: finds the buffer window from the modifier, tests the
// plain sum against it and forms sum -/+ M for the wrapped case.
module agu_mod_wrap #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] mod_m1,
  input  logic [AW:0]   sum_ext,
  input  logic          down,
  output logic          wrap,
  output logic [AW-1:0] result
);
  localparam int SMEAR = $clog2(AW);

  logic [AW-1:0] mask, base, size;
  logic [AW:0]   top_ext;
  logic          wrap_hi, wrap_lo;

  always_comb begin
    mask = mod_m1;
    for (int i = 0; i < SMEAR; i++) begin
      mask = mask | (mask >> (1 << i));
    end
  end

  always_comb begin
    base    = addr & ~mask;
    top_ext = {1'b0, base} + {1'b0, mod_m1};
    size    = mod_m1 + AW'(1);
    wrap_hi = !down && (sum_ext > top_ext);
    wrap_lo = down && (sum_ext[AW] || (sum_ext[AW-1:0] < base));
    wrap    = wrap_hi | wrap_lo;
    result  = wrap_hi ? (sum_ext[AW-1:0] - size) : (sum_ext[AW-1:0] + size);
  end
endmodule

// File: rtl/agu_revcarry_add.sv
// Reverse-carry adder: mirrors both operands, adds or subtracts, mirrors back.
module agu_revcarry_add #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] a,
  input  logic [AW-1:0] b,
  input  logic          down,
  output logic [AW-1:0] y
);
  logic [AW-1:0] ra, rb, rs;

  for (genvar i = 0; i < AW; i++) begin : g_mirror
    assign ra[i]      = a[AW-1-i];
    assign rb[i]      = b[AW-1-i];
    assign y[AW-1-i]  = rs[i];
  end

  always_comb begin
    if (down) rs = ra - rb;
    else      rs = ra + rb;
  end
endmodule

// File: rtl/agu_update.sv
module agu_update #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [AW-1:0] addr_in,
  input  logic [AW-1:0] offset_in,
  input  logic [AW-1:0] modifier_in,
  input  logic [1:0]    step_sel,
  output logic          out_valid,
  output logic [AW-1:0] addr_out
);
  import agu_pkg::*;

  localparam logic [AW-1:0] LIN_CODE = '1;
  localparam logic [AW-1:0] REV_CODE = '0;

  arith_e        mode;
  logic [AW-1:0] mag, lin_sum, mod_sum, rev_sum;
  logic [AW:0]   sum_ext;
  logic          down, wrap;
  logic [AW-1:0] addr_d;
  logic          valid_d;

  always_comb begin
    if (modifier_in == REV_CODE)                               mode = ARITH_REV;
    else if (modifier_in == LIN_CODE || modifier_in[AW-1])     mode = ARITH_LIN;
    else                                                       mode = ARITH_MOD;
  end

  agu_offset_add #(.AW(AW)) u_ofs (
    .addr    (addr_in),
    .offset  (offset_in),
    .step    (step_sel),
    .mag     (mag),
    .down    (down),
    .sum_ext (sum_ext)
  );

  assign lin_sum = sum_ext[AW-1:0];

  agu_mod_wrap #(.AW(AW)) u_mod (
    .addr    (addr_in),
    .mod_m1  (modifier_in),
    .sum_ext (sum_ext),
    .down    (down),
    .wrap    (wrap),
    .result  (mod_sum)
  );

  agu_revcarry_add #(.AW(AW)) u_rev (
    .a    (addr_in),
    .b    (mag),
    .down (down),
    .y    (rev_sum)
  );

  always_comb begin
    valid_d = in_valid;
    addr_d  = addr_out;
    if (in_valid) begin
      unique case (mode)
        ARITH_MOD: addr_d = wrap ? mod_sum : lin_sum;
        ARITH_REV: addr_d = rev_sum;
        default:   addr_d = lin_sum;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      addr_out  <= '0;
    end else begin
      out_valid <= valid_d;
      if (in_valid) addr_out <= addr_d;
    end
  end
endmodule

// File: rtl/agu_update_chk.sv
module agu_update_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [AW-1:0] addr_in,
  input logic [AW-1:0] modifier_in,
  input logic [1:0]    step_sel,
  input logic          out_valid,
  input logic [AW-1:0] addr_out
);
  logic [AW-1:0] cmask;
  logic          is_mod, in_win;

  always_comb begin
    cmask = '0;
    for (int i = 0; i < AW; i++) begin
      if (modifier_in[i]) cmask = AW'((1 << (i + 1)) - 1);
    end
    is_mod = !modifier_in[AW-1] && (modifier_in != '0);
    in_win = (addr_in & cmask) <= modifier_in;
  end

  // R8
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R8
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R8
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(addr_out));

  // R1
  lin_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && modifier_in == '1 && step_sel == 2'b00)
      |=> addr_out == $past(addr_in) + AW'(1));

  // R6
  rev_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && modifier_in == '0 && step_sel[1] == 1'b0)
      |=> addr_out == ($past(addr_in) ^ AW'(1)));

  // R3
  mod_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_mod && in_win && step_sel[1] == 1'b0)
      |=> ((addr_out ^ $past(addr_in)) & ~$past(cmask)) == '0);
endmodule

bind agu_update agu_update_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .addr_in     (addr_in),
  .modifier_in (modifier_in),
  .step_sel    (step_sel),
  .out_valid   (out_valid),
  .addr_out    (addr_out)
);

// File: tb/sim_agu_update.sv
`timescale 1ns/1ps
module sim_agu_update;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] addr_in, offset_in, modifier_in;
  logic [1:0]  step_sel;
  logic        out_valid;
  logic [15:0] addr_out;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  agu_update u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .addr_in(addr_in),
    .offset_in(offset_in), .modifier_in(modifier_in), .step_sel(step_sel),
    .out_valid(out_valid), .addr_out(addr_out)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one update: drive at negedge, result registered at next posedge, sample at following negedge
  task automatic step(input string req, input logic [15:0] a, input logic [15:0] n,
                      input logic [15:0] m, input logic [1:0] op, input logic [15:0] exp);
    @(negedge clk);
    addr_in = a; offset_in = n; modifier_in = m; step_sel = op; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, {15'd0, out_valid}, 16'd1);
    check(req, addr_out, exp);
  endtask

  task automatic t_reset;
    check("R9", {15'd0, out_valid}, 16'd0);
    check("R9", addr_out, 16'h0000);
  endtask

  task automatic t_linear;  // R1
    step("R1", 16'h1234, 16'h0000, 16'hFFFF, 2'b00, 16'h1235);
    step("R1", 16'h0000, 16'h0000, 16'hFFFF, 2'b01, 16'hFFFF);
    step("R1", 16'hFFF0, 16'h0020, 16'hFFFF, 2'b10, 16'h0010);
    step("R1", 16'h0100, 16'h0030, 16'hFFFF, 2'b11, 16'h00D0);
  endtask

  task automatic t_linear_fallback;  // R2
    step("R2", 16'h7FFE, 16'h0005, 16'h8000, 2'b10, 16'h8003);
    step("R2", 16'h0010, 16'h0000, 16'hFFFE, 2'b01, 16'h000F);
  endtask

  task automatic t_mod_inside;  // R3, M=10 at base 0x0100
    step("R3", 16'h0105, 16'h0000, 16'h0009, 2'b00, 16'h0106);
    step("R3", 16'h0108, 16'h0000, 16'h0009, 2'b00, 16'h0109);
    step("R3", 16'h0107, 16'h0002, 16'h0009, 2'b10, 16'h0109);
    step("R3", 16'h0101, 16'h0000, 16'h0009, 2'b01, 16'h0100);
  endtask

  task automatic t_mod_wrap_up;  // R4
    step("R4", 16'h0109, 16'h0000, 16'h0009, 2'b00, 16'h0100);
    step("R4", 16'h0107, 16'h0003, 16'h0009, 2'b10, 16'h0100);
    step("R4", 16'h0108, 16'h000A, 16'h0009, 2'b10, 16'h0108);
    step("R4", 16'hFFFF, 16'h0000, 16'h7FFF, 2'b00, 16'h8000);
  endtask

  task automatic t_mod_wrap_down;  // R5
    step("R5", 16'h0100, 16'h0000, 16'h0009, 2'b01, 16'h0109);
    step("R5", 16'h0102, 16'h0005, 16'h0009, 2'b11, 16'h0107);
    step("R5", 16'h0000, 16'h0000, 16'h0007, 2'b01, 16'h0007);
  endtask

  task automatic t_rev_forward;  // R6
    logic [15:0] seq [8] = '{16'h8000, 16'h4000, 16'hC000, 16'h2000,
                             16'hA000, 16'h6000, 16'hE000, 16'h1000};
    logic [15:0] cur = 16'h0000;
    for (int i = 0; i < 8; i++) begin
      step("R6", cur, 16'h8000, 16'h0000, 2'b10, seq[i]);
      cur = seq[i];
    end
    step("R6", 16'h0006, 16'h0000, 16'h0000, 2'b00, 16'h0007);
  endtask

  task automatic t_rev_backward;  // R7
    step("R7", 16'hC000, 16'h8000, 16'h0000, 2'b11, 16'h4000);
    step("R7", 16'h4000, 16'h8000, 16'h0000, 2'b11, 16'h8000);
    step("R7", 16'h8000, 16'h8000, 16'h0000, 2'b11, 16'h0000);
    step("R7", 16'h0000, 16'h0000, 16'h0000, 2'b01, 16'h0001);
  endtask

  task automatic t_latency_hold;  // R8
    step("R8", 16'h2000, 16'h0000, 16'hFFFF, 2'b00, 16'h2001);
    @(negedge clk);
    addr_in = 16'h5555; offset_in = 16'h0F0F; modifier_in = 16'h0000; step_sel = 2'b10;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R8", {15'd0, out_valid}, 16'd0);
      check("R8", addr_out, 16'h2001);
    end
    // back-to-back updates, one result per cycle
    @(negedge clk);
    addr_in = 16'h0040; modifier_in = 16'hFFFF; step_sel = 2'b00; in_valid = 1'b1;
    @(negedge clk);
    check("R8", {15'd0, out_valid}, 16'd1);
    check("R8", addr_out, 16'h0041);
    addr_in = 16'h0050; step_sel = 2'b01;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8", {15'd0, out_valid}, 16'd1);
    check("R8", addr_out, 16'h004F);
    @(negedge clk);
    check("R8", {15'd0, out_valid}, 16'd0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0;
    addr_in = '0; offset_in = '0; modifier_in = '0; step_sel = 2'b00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_linear();
    t_linear_fallback();
    t_mod_inside();
    t_mod_wrap_up();
    t_mod_wrap_down();
    t_rev_forward();
    t_rev_backward();
    t_latency_hold();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule